// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block judges every bus access against a set of programmable protection regions and says at once whether the access may proceed. Each region has an aligned base address, a power-of-two size, a mask that carves eight equal slices out of it, and a three-bit permission code. It also carries a flag that forbids instruction fetch. Privileged and unprivileged requesters are judged by separate rules. Where regions overlap, the region with the highest index decides.

Software sets the regions up through a small word-wide register port with four locations. A select register chooses which region the base and attribute locations refer to. A global control bit switches checking on. While the bit is clear, every access is allowed.

The access port is purely combinational toward `acc_allow`. A rejected access that carries `acc_valid` raises a fault pulse one cycle later. The first rejected address and its access kind are kept until software clears them.

Top module: `region_guard`

## Requirements
- R1: After reset the control bit and every region's attribute word read back as 0, no fault is held, and every access is allowed.
- R2: Config addresses are 0 = control (bit 0 = enable), 1 = region select, 2 = region base, 3 = region attribute. Base and attribute writes and reads apply only to the selected region. Base bits [7:0] read as 0. Attribute reads return only bit 0 (enable), bits [5:1] (SIZE), bits [15:8] (slice-disable mask), bits [26:24] (permission code) and bit 28 (no-fetch); all other bits read as 0.
- R3: While the control enable is 0, `acc_allow` is 1 for every access and no fault is raised.
- R4: An enabled region covers 2^(SIZE+1) bytes starting at its base, aligned to that size; base bits below the size are ignored. SIZE values below 7 are treated as 7 (256 bytes).
- R5: When an address matches several enabled regions, only the highest-numbered match decides.
- R6: Attribute bit 8+k excludes slice k (slice 0 at the lowest address, each slice one eighth of the region) from that region's match, so lower regions or the default rule decide there.
- R7: Permission codes: 0 no access; 1 privileged read/write only; 2 privileged read/write, unprivileged read; 3 read/write for both; 5 privileged read only; 6 read only for both; 4 and 7 no access.
- R8: Access kind encoding is 0 = read, 1 = write, 2 = fetch. A fetch needs read permission and is rejected in a region whose no-fetch bit is set.
- R9: With checking on, a privileged access that matches no region is allowed and an unprivileged one is rejected.
- R10: `fault_pulse` is high for exactly the cycle after a cycle in which `acc_valid` was 1 and `acc_allow` was 0. A rejected address presented without `acc_valid` raises nothing.
- R11: The first fault sets `fault_vld` and latches its address and kind. Later faults leave them unchanged until `fault_clr` drops `fault_vld`, after which the next fault is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config location |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr` (combinational) |
| acc_valid | input | 1 | Access is real and may fault |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 = privileged requester |
| fault_clr | input | 1 | Drops the held fault |
| acc_allow | output | 1 | Access permitted (combinational) |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_vld | output | 1 | A fault is held |
| fault_addr | output | 32 | Address of the held fault |
| fault_kind | output | 2 | Access kind of the held fault |

## Verification
The assertions take `acc_kind` to be one of the three defined kinds and the fault clear to be a separate event from the fault it clears. The bench keeps kind 3 off the port and never raises `fault_clr` in a cycle with a rejected valid access. Permission probes run with `acc_valid` low, so they never raise a fault. Real faulting accesses are issued one at a time, with an idle cycle between them, so that each pulse can be tied to its own access.

// File: rtl/rguard_pkg.sv
package rguard_pkg;
   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   localparam int EN_BIT   = 0;
   localparam int SIZE_LSB = 1;
   localparam int SIZE_W   = 5;
   localparam int SRD_LSB  = 8;
   localparam int AP_LSB   = 24;
   localparam int AP_W     = 3;
   localparam int XN_BIT   = 28;
   localparam int MIN_SIZE = 7;

   localparam logic [1:0] CFG_CTRL = 2'd0;
   localparam logic [1:0] CFG_SEL  = 2'd1;
   localparam logic [1:0] CFG_BASE = 2'd2;
   localparam logic [1:0] CFG_ATTR = 2'd3;

   function automatic logic perm_ok(input logic [AP_W-1:0] ap, input logic priv, input logic wr);
      logic ok;
      case (ap)
         3'd1:    ok = priv;
         3'd2:    ok = priv | ~wr;
         3'd3:    ok = 1'b1;
         3'd5:    ok = priv & ~wr;
         3'd6:    ok = ~wr;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/rg_region_match.sv
module rg_region_match
   import rguard_pkg::*;
#(
   parameter int W     = 32,
   parameter int SUB_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [W-1:0]      base,
   input  logic [SIZE_W-1:0] size,
   input  logic [SUB_N-1:0]  sub_off,
   input  logic [W-1:0]      addr,
   output logic              hit
);
   localparam int SUB_W = $clog2(SUB_N);
   localparam logic [5:0] SUB_W6 = 6'(SUB_W);

   generate
      if (SUB_N != (1 << SUB_W)) begin : g_bad_sub
         $error("SUB_N must be a power of two");
      end
      if (MIN_SIZE + 1 < SUB_W) begin : g_bad_min
         $error("minimum region too small for slice count");
      end
   endgenerate

   logic [SIZE_W-1:0] sz_eff;
   logic [5:0]        top_sh, sub_sh;
   logic [W-1:0]      a_top, b_top, a_sub;
   logic [SUB_W-1:0]  slice;

   always_comb begin
      sz_eff = (size < SIZE_W'(MIN_SIZE)) ? SIZE_W'(MIN_SIZE) : size;
      top_sh = {1'b0, sz_eff} + 6'd1;
      sub_sh = top_sh - SUB_W6;
      a_top  = addr >> top_sh;
      b_top  = base >> top_sh;
      a_sub  = addr >> sub_sh;
      slice  = a_sub[SUB_W-1:0];
      hit    = enable && (a_top == b_top) && !sub_off[slice];
   end

   // R4: a disabled region never matches
   p_hit_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> enable);
endmodule

// File: rtl/rg_resolve.sv
module rg_resolve
   import rguard_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ctrl_en,
   input  logic [NUM_REGIONS-1:0]          hit,
   input  logic [NUM_REGIONS-1:0][AP_W-1:0] ap,
   input  logic [NUM_REGIONS-1:0]          xn,
   input  logic [1:0]                      kind,
   input  logic                            priv,
   output logic                            allow
);
   localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

   logic             any;
   logic [SEL_W-1:0] win;
   logic             is_wr, is_fx;

   always_comb begin
      any = 1'b0;
      win = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit[i]) begin
            any = 1'b1;
            win = SEL_W'(i);
         end
      end
      is_wr = (kind == ACC_WRITE);
      is_fx = (kind == ACC_FETCH);
      if (!ctrl_en)
         allow = 1'b1;
      else if (!any)
         allow = priv;
      else
         allow = perm_ok(ap[win], priv, is_wr) && !(is_fx && xn[win]);
   end

   // R3: checking off lets everything through
   p_off_allows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> allow);
   // R9: default rule for accesses outside every region
   p_bg_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && hit == '0 && priv) |-> allow);
   p_bg_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && hit == '0 && !priv) |-> !allow);
   // R8: fetch is never allowed where writes alone would be refused and reads too
   p_fx_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && kind == ACC_FETCH && $onehot0(hit) && hit != '0 && ap[0] == 3'd0 && hit[0]) |-> !allow);
endmodule

// File: rtl/region_guard.sv
module region_guard
   import rguard_pkg::*;
#(
   parameter int W           = 32,
   parameter int NUM_REGIONS = 8,
   parameter int SUB_N       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_wr,
   input  logic [1:0]   cfg_addr,
   input  logic [W-1:0] cfg_wdata,
   output logic [W-1:0] cfg_rdata,
   input  logic         acc_valid,
   input  logic [W-1:0] acc_addr,
   input  logic [1:0]   acc_kind,
   input  logic         acc_priv,
   input  logic         fault_clr,
   output logic         acc_allow,
   output logic         fault_pulse,
   output logic         fault_vld,
   output logic [W-1:0] fault_addr,
   output logic [1:0]   fault_kind
);
   localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam logic [W-1:0] ATTR_MASK = W'((1 << EN_BIT) | (((1 << SIZE_W) - 1) << SIZE_LSB)
                                     | (((1 << SUB_N) - 1) << SRD_LSB)
                                     | (((1 << AP_W) - 1) << AP_LSB) | (1 << XN_BIT));
   localparam logic [W-1:0] BASE_MASK = ~W'(255);
   localparam logic [W-1:0] SEL_MASK  = W'(NUM_REGIONS - 1);

   generate
      if (NUM_REGIONS != (1 << SEL_W)) begin : g_bad_n
         $error("NUM_REGIONS must be a power of two");
      end
      if (W < XN_BIT + 1) begin : g_bad_w
         $error("W too narrow for attribute layout");
      end
      if (SRD_LSB + SUB_N > AP_LSB) begin : g_bad_sub
         $error("slice mask overlaps permission field");
      end
   endgenerate

   logic [W-1:0] ctrl_q, sel_q;
   logic [W-1:0] base_q [NUM_REGIONS];
   logic [W-1:0] attr_q [NUM_REGIONS];
   logic [SEL_W-1:0] sel;

   assign sel = sel_q[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sel_q  <= '0;
         for (int i = 0; i < NUM_REGIONS; i++) begin
            base_q[i] <= '0;
            attr_q[i] <= '0;
         end
      end else if (cfg_wr) begin
         case (cfg_addr)
            CFG_CTRL: ctrl_q       <= cfg_wdata & W'(1);
            CFG_SEL:  sel_q        <= cfg_wdata & SEL_MASK;
            CFG_BASE: base_q[sel]  <= cfg_wdata & BASE_MASK;
            default:  attr_q[sel]  <= cfg_wdata & ATTR_MASK;
         endcase
      end
   end

   always_comb begin
      case (cfg_addr)
         CFG_CTRL: cfg_rdata = ctrl_q;
         CFG_SEL:  cfg_rdata = sel_q;
         CFG_BASE: cfg_rdata = base_q[sel];
         default:  cfg_rdata = attr_q[sel];
      endcase
   end

   logic [NUM_REGIONS-1:0]           hit;
   logic [NUM_REGIONS-1:0][AP_W-1:0] ap;
   logic [NUM_REGIONS-1:0]           xn;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      assign ap[g] = attr_q[g][AP_LSB +: AP_W];
      assign xn[g] = attr_q[g][XN_BIT];
      rg_region_match #(.W(W), .SUB_N(SUB_N)) u_match (
         .clk     (clk),
         .rst_n   (rst_n),
         .enable  (attr_q[g][EN_BIT]),
         .base    (base_q[g]),
         .size    (attr_q[g][SIZE_LSB +: SIZE_W]),
         .sub_off (attr_q[g][SRD_LSB +: SUB_N]),
         .addr    (acc_addr),
         .hit     (hit[g])
      );
   end

   rg_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_resolve (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_en (ctrl_q[0]),
      .hit     (hit),
      .ap      (ap),
      .xn      (xn),
      .kind    (acc_kind),
      .priv    (acc_priv),
      .allow   (acc_allow)
   );

   logic reject;
   assign reject = acc_valid && !acc_allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_pulse <= 1'b0;
         fault_vld   <= 1'b0;
         fault_addr  <= '0;
         fault_kind  <= '0;
      end else begin
         fault_pulse <= reject;
         if (reject && !fault_vld) begin
            fault_vld  <= 1'b1;
            fault_addr <= acc_addr;
            fault_kind <= acc_kind;
         end else if (fault_clr) begin
            fault_vld <= 1'b0;
         end
      end
   end

   // R10: a rejected valid access is reported in the next cycle
   p_fault_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_allow) |=> fault_pulse);
   p_no_fault_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !fault_pulse);
   // R11: held fault information does not move until cleared
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld && !fault_clr) |=> (fault_vld && $stable(fault_addr) && $stable(fault_kind)));
   // R3: no fault while checking is off
   p_off_nofault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |=> !fault_pulse);
endmodule

// File: tb/region_guard_tb.sv
module region_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = 2'd0;
   logic        acc_priv = 1'b0;
   logic        fault_clr = 1'b0;
   logic        acc_allow, fault_pulse, fault_vld;
   logic [31:0] fault_addr;
   logic [1:0]  fault_kind;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   region_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
      .fault_clr(fault_clr), .acc_allow(acc_allow), .fault_pulse(fault_pulse),
      .fault_vld(fault_vld), .fault_addr(fault_addr), .fault_kind(fault_kind)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1 chk(req, cfg_rdata, exp);
   endtask

   task automatic probe(input string req, input logic [31:0] a, input logic [1:0] k,
                        input logic p, input logic exp);
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = a; acc_kind = k; acc_priv = p;
      #1 chk(req, {31'd0, acc_allow}, {31'd0, exp});
   endtask

   // One valid access; returns the fault pulse seen in the following cycle
   task automatic access(input logic [31:0] a, input logic [1:0] k, input logic p,
                         output logic pulse);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
      @(negedge clk);
      acc_valid = 1'b0;
      pulse = fault_pulse;
   endtask

   task automatic region(input int n, input logic [31:0] b, input logic [31:0] at);
      wr(2'd1, n);
      wr(2'd2, b);
      wr(2'd3, at);
   endtask

   task automatic t_reset();
      rd("R1 ctrl", 2'd0, 32'h0);
      rd("R1 attr", 2'd3, 32'h0);
      chk("R1 fault_vld", {31'd0, fault_vld}, 32'h0);
      probe("R1 allow", 32'h1234_5678, 2'd1, 1'b0, 1'b1);
   endtask

   task automatic t_config();
      wr(2'd1, 32'd3);
      wr(2'd2, 32'h2000_01FF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd("R2 base low bits", 2'd2, 32'h2000_0100);
      rd("R2 attr fields", 2'd3, 32'h1700_FF3F);
      wr(2'd1, 32'd2);
      rd("R2 other region", 2'd3, 32'h0);
      wr(2'd1, 32'd3);
      wr(2'd3, 32'h0);
      wr(2'd2, 32'h0);
   endtask

   task automatic t_disabled();
      logic p;
      region(0, 32'h2000_0000, 32'h0000_001F);
      probe("R3 off allow", 32'h2000_0010, 2'd1, 1'b0, 1'b1);
      access(32'h9000_0000, 2'd1, 1'b0, p);
      chk("R3 off no fault", {31'd0, p}, 32'h0);
   endtask

   task automatic t_setup();
      region(0, 32'h2000_0000, 32'h0300_001F);
      region(1, 32'h2000_0000, 32'h0600_0217);
      region(2, 32'h0800_0000, 32'h0500_001D);
      region(3, 32'h4000_0000, 32'h1100_001B);
      region(4, 32'h6000_0000, 32'h0300_0007);
      region(5, 32'h7000_0000, 32'h0200_0013);
      region(6, 32'h7000_1000, 32'h0000_0013);
      wr(2'd0, 32'h1);
   endtask

   task automatic t_size();
      probe("R4 inside 64K", 32'h2000_8000, 2'd1, 1'b0, 1'b1);
      probe("R4 past end", 32'h2001_0000, 2'd0, 1'b0, 1'b0);
      probe("R4 min size in", 32'h6000_00F0, 2'd0, 1'b0, 1'b1);
      probe("R4 min size out", 32'h6000_0100, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_overlap();
      probe("R5 high wins write", 32'h2000_0010, 2'd1, 1'b0, 1'b0);
      probe("R5 high wins read", 32'h2000_0010, 2'd0, 1'b0, 1'b1);
   endtask

   task automatic t_slice();
      probe("R6 slice off", 32'h2000_0210, 2'd1, 1'b0, 1'b1);
      probe("R6 slice on", 32'h2000_0410, 2'd1, 1'b0, 1'b0);
   endtask

   task automatic t_perm();
      probe("R7 ap5 priv rd", 32'h0800_0100, 2'd0, 1'b1, 1'b1);
      probe("R7 ap5 priv wr", 32'h0800_0100, 2'd1, 1'b1, 1'b0);
      probe("R7 ap5 user rd", 32'h0800_0100, 2'd0, 1'b0, 1'b0);
      probe("R7 ap1 priv wr", 32'h4000_0100, 2'd1, 1'b1, 1'b1);
      probe("R7 ap1 user rd", 32'h4000_0100, 2'd0, 1'b0, 1'b0);
      probe("R7 ap2 priv wr", 32'h7000_0100, 2'd1, 1'b1, 1'b1);
      probe("R7 ap2 user rd", 32'h7000_0100, 2'd0, 1'b0, 1'b1);
      probe("R7 ap2 user wr", 32'h7000_0100, 2'd1, 1'b0, 1'b0);
      probe("R7 ap0 priv rd", 32'h7000_1100, 2'd0, 1'b1, 1'b0);
      probe("R7 ap3 user wr", 32'h2000_8000, 2'd1, 1'b0, 1'b1);
   endtask

   task automatic t_fetch();
      probe("R8 no-fetch", 32'h4000_0100, 2'd2, 1'b1, 1'b0);
      probe("R8 fetch priv ro", 32'h0800_0100, 2'd2, 1'b1, 1'b1);
      probe("R8 fetch user ro", 32'h2000_0010, 2'd2, 1'b0, 1'b1);
      probe("R8 fetch no read", 32'h0800_0100, 2'd2, 1'b0, 1'b0);
   endtask

   task automatic t_default();
      probe("R9 priv unmapped", 32'h9000_0000, 2'd1, 1'b1, 1'b1);
      probe("R9 user unmapped", 32'h9000_0000, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_fault();
      logic p;
      probe("R10 probe only", 32'h9000_0000, 2'd0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R10 no pulse without valid", {31'd0, fault_pulse}, 32'h0);
      chk("R10 nothing held", {31'd0, fault_vld}, 32'h0);
      access(32'h2000_8000, 2'd1, 1'b0, p);
      chk("R10 allowed no pulse", {31'd0, p}, 32'h0);
      access(32'h9000_0040, 2'd0, 1'b0, p);
      chk("R10 pulse", {31'd0, p}, 32'h1);
      @(negedge clk);
      chk("R10 pulse one cycle", {31'd0, fault_pulse}, 32'h0);
      chk("R11 vld", {31'd0, fault_vld}, 32'h1);
      chk("R11 addr", fault_addr, 32'h9000_0040);
      chk("R11 kind", {30'd0, fault_kind}, 32'h0);
      access(32'h4000_0080, 2'd2, 1'b1, p);
      chk("R10 second pulse", {31'd0, p}, 32'h1);
      chk("R11 first kept", fault_addr, 32'h9000_0040);
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
      chk("R11 cleared", {31'd0, fault_vld}, 32'h0);
      access(32'h4000_0080, 2'd2, 1'b1, p);
      @(negedge clk);
      chk("R11 new addr", fault_addr, 32'h4000_0080);
      chk("R11 new kind", {30'd0, fault_kind}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_disabled();
      t_setup();
      t_size();
      t_overlap();
      t_slice();
      t_perm();
      t_fetch();
      t_default();
      t_fault();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule